// File: doc/BRIEF.md
# DAC Output Update and Clear Controller

This block decides which code the converter core of a precision voltage-output DAC receives. It holds two registers: the DAC register, which takes new codes from the register interface, and the output code register, which drives the core. Three active-low pins control it: a load pin, a clear pin and a reset pin. Each pin passes through a synchronizer into the system clock domain, and its edges are detected there. Single-cycle software strobes from the register interface give software the same load, clear and reset actions.

A low load pin makes the output follow the DAC register continuously. A falling edge on the load pin copies the DAC register to the output once. A low clear pin overrides loading: it forces both registers to the value of an external clearcode register. While the reset pin is low, the block ignores all programming. When the reset pin rises, or the software reset strobe fires, the block returns to its power-on state and sends a one-cycle reset request to the register file. A clamp flag leaves the block with the output code. It stays asserted from power-on until the control register releases the clamp.

Top module: `dac_update_ctrl`

## Requirements
- R1: After the synchronous system reset, the DAC register and the output code are zero, the clamp flag is 1 and the reset request is 0.
- R2: While the synchronized reset pin is low, the block ignores DAC register writes, software strobes and clear pin activity. The DAC register and output code hold, and the clamp flag is 1.
- R3: A rising edge on the reset pin sets the DAC register and output code to zero and the clamp flag to 1, and raises the reset request for exactly one cycle.
- R4: A software reset strobe has the same effect as R3, at the clock edge where the strobe is sampled.
- R5: While the clear pin is low, both the DAC register and the output code take the clearcode input, at any load pin level. DAC register writes are ignored during this time.
- R6: When the clear pin rises with the load pin high, the output stays at the clearcode. When it rises with the load pin low, the output returns to tracking the DAC register.
- R7: While the load pin is low, the output code equals the DAC register value of the previous cycle. A write therefore reaches the output one cycle after it reaches the DAC register.
- R8: While the load pin is high, writes change only the DAC register. A falling edge on the load pin copies the DAC register to the output. A rising edge leaves the output unchanged.
- R9: A software load strobe with the load pin high copies the DAC register to the output at the clock edge where the strobe is sampled.
- R10: A software clear strobe with the clear pin high loads the clearcode into both the DAC register and the output code at the clock edge where the strobe is sampled.
- R11: A pin change applied between clock edges shows at the outputs on the third rising edge after the change, and not before.
- R12: Outside reset, the clamp flag follows the control register's clamp bit with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ldac_n | input | 1 | Load pin, active low, asynchronous |
| clr_n | input | 1 | Clear pin, active low, asynchronous |
| reset_n | input | 1 | Reset pin, active low, asynchronous |
| sw_ldac | input | 1 | Software load strobe, one cycle |
| sw_clr | input | 1 | Software clear strobe, one cycle |
| sw_reset | input | 1 | Software reset strobe, one cycle |
| dac_wr_en | input | 1 | Write strobe for the DAC register |
| dac_wr_code | input | CODE_W | Code written into the DAC register |
| clearcode | input | CODE_W | Current clearcode register value |
| clamp_ctl | input | 1 | Clamp bit from the control register |
| dac_code | output | CODE_W | DAC register contents |
| out_code | output | CODE_W | Code driving the converter core |
| out_clamped | output | 1 | Output is clamped |
| regfile_rst | output | 1 | One-cycle reset request for the register file |

## Verification
The bench builds the block with CODE_W = 6, so every one of the 64 codes can be written. It sweeps all of them through a held DAC register with the load pin high, through transparent tracking with the load pin low, and through the software clear path with every clearcode paired against its complement. The small width leaves cycles for directed sequences that cover every pin edge combination. These include clear releases at both load levels, programming attempts during reset, and the exact three-edge pin latency.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

  // Action applied to the code registers on the next clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_LOAD    = 2'd1,
    ACT_CLEAR   = 2'd2,
    ACT_DEFAULT = 2'd3
  } upd_act_e;

  // Bit positions of the pins in the synchronized vectors.
  localparam int PIN_LDAC  = 0;
  localparam int PIN_CLR   = 1;
  localparam int PIN_RESET = 2;
  localparam int N_PINS    = 3;

endpackage

// File: rtl/dac_pin_sync.sv
// Multi-stage synchronizer for the active-low control pins, plus a
// one-cycle-delayed copy so that edges can be formed downstream.
module dac_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);

  localparam int LAST = STAGES - 1;

  logic [N-1:0] chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '1;
          else     chain[g] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prv <= '1;
    else     prv <= chain[LAST];
  end

  assign lvl = chain[LAST];

endmodule

// File: rtl/dac_upd_arbiter.sv
// Priority decision between reset, clear and load sources.
module dac_upd_arbiter
  import dac_upd_pkg::*;
#(
  parameter int N = N_PINS
) (
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] prv,
  input  logic         sw_ldac,
  input  logic         sw_clr,
  input  logic         sw_reset,
  output upd_act_e     act,
  output logic         wr_ok,
  output logic         hold_rst
);

  logic rst_low, rst_rise, clr_low, clr_rise, ldac_low, ldac_fall;

  always_comb begin
    rst_low   = !lvl[PIN_RESET];
    rst_rise  = lvl[PIN_RESET] && !prv[PIN_RESET];
    clr_low   = !lvl[PIN_CLR];
    clr_rise  = lvl[PIN_CLR] && !prv[PIN_CLR];
    ldac_low  = !lvl[PIN_LDAC];
    ldac_fall = !lvl[PIN_LDAC] && prv[PIN_LDAC];
  end

  always_comb begin
    act      = ACT_HOLD;
    wr_ok    = 1'b0;
    hold_rst = 1'b0;
    if (rst_low) begin
      hold_rst = 1'b1;
    end else if (rst_rise || sw_reset) begin
      act = ACT_DEFAULT;
    end else if (clr_low) begin
      act = ACT_CLEAR;
    end else if (clr_rise) begin
      // Leaving clear: output returns to the DAC register only if
      // the load pin is already low; otherwise it keeps the clearcode.
      wr_ok = 1'b1;
      act   = ldac_low ? ACT_LOAD : ACT_HOLD;
    end else if (sw_clr) begin
      act = ACT_CLEAR;
    end else begin
      wr_ok = 1'b1;
      // Edge term kept explicit: the falling edge is the one-shot
      // update, the low level is the transparent update.
      if (ldac_fall || ldac_low || sw_ldac) act = ACT_LOAD;
    end
  end

endmodule

// File: rtl/dac_code_regs.sv
// DAC register, output code register, clamp flag and reset request.
module dac_code_regs
  import dac_upd_pkg::*;
#(
  parameter int CODE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  upd_act_e          act,
  input  logic              wr_ok,
  input  logic              hold_rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [CODE_W-1:0] clearcode,
  input  logic              clamp_ctl,
  output logic [CODE_W-1:0] dac_q,
  output logic [CODE_W-1:0] out_q,
  output logic              clamped_q,
  output logic              req_q
);

  localparam logic [CODE_W-1:0] POR_CODE = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_q <= POR_CODE;
    end else begin
      unique case (act)
        ACT_DEFAULT: dac_q <= POR_CODE;
        ACT_CLEAR:   dac_q <= clearcode;
        default: if (wr_ok && wr_en) dac_q <= wr_code;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= POR_CODE;
    end else begin
      unique case (act)
        ACT_DEFAULT: out_q <= POR_CODE;
        ACT_CLEAR:   out_q <= clearcode;
        ACT_LOAD:    out_q <= dac_q;
        default:     out_q <= out_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clamped_q <= 1'b1;
      req_q     <= 1'b0;
    end else begin
      req_q     <= (act == ACT_DEFAULT);
      clamped_q <= (act == ACT_DEFAULT) || hold_rst || clamp_ctl;
    end
  end

  // R2: held reset freezes both code registers
  a_r2_hold_in_reset: assert property (@(posedge clk) disable iff (rst)
    hold_rst |=> ($stable(dac_q) && $stable(out_q) && clamped_q));

  // R3/R4: a return to defaults clears the codes and requests a reset
  a_r3_default_state: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_DEFAULT) |=> (dac_q == '0 && out_q == '0 && clamped_q && req_q));

  // R5/R10: clearing places the clearcode in both registers
  a_r5_clear_loads: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_CLEAR) |=> (dac_q == $past(clearcode) && out_q == $past(clearcode)));

  // R7/R8/R9: a load copies the previous DAC register to the output
  a_r7_load_copies: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_LOAD) |=> (out_q == $past(dac_q)));

  // R8: an idle cycle leaves the output untouched
  a_r8_hold_output: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |=> $stable(out_q));

endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_upd_pkg::*;
#(
  parameter int CODE_W      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ldac_n,
  input  logic              clr_n,
  input  logic              reset_n,
  input  logic              sw_ldac,
  input  logic              sw_clr,
  input  logic              sw_reset,
  input  logic              dac_wr_en,
  input  logic [CODE_W-1:0] dac_wr_code,
  input  logic [CODE_W-1:0] clearcode,
  input  logic              clamp_ctl,
  output logic [CODE_W-1:0] dac_code,
  output logic [CODE_W-1:0] out_code,
  output logic              out_clamped,
  output logic              regfile_rst
);

  logic [N_PINS-1:0] pins_n, lvl, prv;
  upd_act_e          act;
  logic              wr_ok, hold_rst;

  always_comb begin
    pins_n            = '1;
    pins_n[PIN_LDAC]  = ldac_n;
    pins_n[PIN_CLR]   = clr_n;
    pins_n[PIN_RESET] = reset_n;
  end

  dac_pin_sync #(.N(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (pins_n),
    .lvl   (lvl),
    .prv   (prv)
  );

  dac_upd_arbiter #(.N(N_PINS)) u_arb (
    .lvl      (lvl),
    .prv      (prv),
    .sw_ldac  (sw_ldac),
    .sw_clr   (sw_clr),
    .sw_reset (sw_reset),
    .act      (act),
    .wr_ok    (wr_ok),
    .hold_rst (hold_rst)
  );

  dac_code_regs #(.CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .wr_ok     (wr_ok),
    .hold_rst  (hold_rst),
    .wr_en     (dac_wr_en),
    .wr_code   (dac_wr_code),
    .clearcode (clearcode),
    .clamp_ctl (clamp_ctl),
    .dac_q     (dac_code),
    .out_q     (out_code),
    .clamped_q (out_clamped),
    .req_q     (regfile_rst)
  );

  // R3: a register-file reset request always comes with the clamp set
  a_r3_req_with_clamp: assert property (@(posedge clk) disable iff (rst)
    regfile_rst |-> out_clamped);

endmodule

// File: tb/tb_dac_update_ctrl.sv
module tb_dac_update_ctrl;

  localparam int  CODE_W  = 6;
  localparam int  NCODES  = 1 << CODE_W;
  localparam time T_CLK   = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ldac_n = 1'b1, clr_n = 1'b1, reset_n = 1'b1;
  logic sw_ldac = 1'b0, sw_clr = 1'b0, sw_reset = 1'b0;
  logic dac_wr_en = 1'b0;
  logic [CODE_W-1:0] dac_wr_code = '0;
  logic [CODE_W-1:0] clearcode = '0;
  logic clamp_ctl = 1'b1;
  logic [CODE_W-1:0] dac_code, out_code;
  logic out_clamped, regfile_rst;

  int n_vec = 0;
  int n_bad = 0;

  always #(T_CLK/2) clk = ~clk;

  dac_update_ctrl #(.CODE_W(CODE_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .ldac_n(ldac_n), .clr_n(clr_n), .reset_n(reset_n),
    .sw_ldac(sw_ldac), .sw_clr(sw_clr), .sw_reset(sw_reset),
    .dac_wr_en(dac_wr_en), .dac_wr_code(dac_wr_code), .clearcode(clearcode),
    .clamp_ctl(clamp_ctl), .dac_code(dac_code), .out_code(out_code),
    .out_clamped(out_clamped), .regfile_rst(regfile_rst)
  );

  // n rising edges, then settle at the following falling edge
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int v);
    dac_wr_en   = 1'b1;
    dac_wr_code = v[CODE_W-1:0];
    tick(1);
    dac_wr_en   = 1'b0;
  endtask

  task automatic pulse_sw_ldac();
    sw_ldac = 1'b1; tick(1); sw_ldac = 1'b0;
  endtask

  task automatic pulse_sw_clr();
    sw_clr = 1'b1; tick(1); sw_clr = 1'b0;
  endtask

  initial begin
    #(T_CLK * 200000);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1: power-on state
    chk("R1 dac", dac_code, 0);
    chk("R1 out", out_code, 0);
    chk("R1 clamp", out_clamped, 1);
    chk("R1 req", regfile_rst, 0);

    // R8: load pin high, every code lands only in the DAC register
    for (int v = 0; v < NCODES; v++) begin
      wr(v);
      chk("R8 dac", dac_code, v);
      chk("R8 out held", out_code, 0);
    end

    // R11: pin latency of three rising edges
    wr(42);
    ldac_n = 1'b0;
    tick(2);
    chk("R11 not yet", out_code, 0);
    tick(1);
    chk("R11 on third edge", out_code, 42);

    // R7: transparent tracking, one cycle behind the DAC register
    begin
      int prev;
      prev = 42;
      for (int v = 0; v < NCODES; v++) begin
        wr(v);
        chk("R7 dac", dac_code, v);
        chk("R7 out lags", out_code, prev);
        tick(1);
        chk("R7 out follows", out_code, v);
        prev = v;
      end
    end

    // R8: rising edge holds, falling edge loads
    wr(5); tick(1);
    chk("R7 out", out_code, 5);
    ldac_n = 1'b1; tick(4);
    wr(9); tick(3);
    chk("R8 rise holds", out_code, 5);
    chk("R8 dac", dac_code, 9);
    ldac_n = 1'b0; tick(4);
    chk("R8 fall loads", out_code, 9);
    ldac_n = 1'b1; tick(4);

    // R9: software load with pin high
    wr(17); tick(2);
    chk("R9 before", out_code, 9);
    pulse_sw_ldac();
    chk("R9 sw load", out_code, 17);

    // R10: software clear over all clearcodes
    for (int c = 0; c < NCODES; c++) begin
      clearcode = c[CODE_W-1:0];
      wr(c ^ (NCODES - 1));
      pulse_sw_clr();
      chk("R10 out", out_code, c);
      chk("R10 dac", dac_code, c);
    end

    // R5: clear pin overrides writes and load pin level
    clearcode = 6'd33;
    wr(3); pulse_sw_ldac();
    chk("R9 out", out_code, 3);
    clr_n = 1'b0; tick(4);
    chk("R5 out", out_code, 33);
    chk("R5 dac", dac_code, 33);
    wr(7); tick(2);
    chk("R5 write ignored", dac_code, 33);
    ldac_n = 1'b0; tick(4);
    chk("R5 ldac low", out_code, 33);
    ldac_n = 1'b1; tick(4);

    // R6: clear release with load pin high keeps clearcode
    clr_n = 1'b1; tick(4);
    chk("R6 keep", out_code, 33);
    wr(12); tick(3);
    chk("R6 keep after write", out_code, 33);
    chk("R6 dac", dac_code, 12);
    // R6: clear release with load pin low returns to tracking
    clr_n = 1'b0; tick(4);
    ldac_n = 1'b0; tick(4);
    clr_n = 1'b1; tick(4);
    chk("R6 release low", out_code, 33);
    wr(20); tick(1);
    chk("R6 tracking", out_code, 20);
    ldac_n = 1'b1; tick(4);

    // R12: clamp follows control bit
    clamp_ctl = 1'b0; tick(1);
    chk("R12 clamp off", out_clamped, 0);

    // R2: reset pin low ignores programming
    reset_n = 1'b0; tick(4);
    chk("R2 clamp", out_clamped, 1);
    wr(50);
    pulse_sw_clr();
    pulse_sw_ldac();
    clr_n = 1'b0; tick(4);
    clr_n = 1'b1; tick(4);
    chk("R2 dac", dac_code, 20);
    chk("R2 out", out_code, 20);
    chk("R2 req", regfile_rst, 0);

    // R3: rising edge of reset pin
    reset_n = 1'b1;
    tick(2);
    chk("R3 req early", regfile_rst, 0);
    tick(1);
    chk("R3 req", regfile_rst, 1);
    chk("R3 out", out_code, 0);
    chk("R3 dac", dac_code, 0);
    chk("R3 clamp", out_clamped, 1);
    tick(1);
    chk("R3 req single", regfile_rst, 0);
    chk("R12 clamp after reset", out_clamped, 0);

    // R4: software reset
    ldac_n = 1'b0; tick(4);
    wr(40); tick(1);
    chk("R7 out", out_code, 40);
    sw_reset = 1'b1; tick(1); sw_reset = 1'b0;
    chk("R4 out", out_code, 0);
    chk("R4 dac", dac_code, 0);
    chk("R4 req", regfile_rst, 1);
    chk("R4 clamp", out_clamped, 1);
    tick(1);
    chk("R4 req single", regfile_rst, 0);

    // R12: toggling the clamp bit
    clamp_ctl = 1'b1; tick(1);
    chk("R12 on", out_clamped, 1);
    clamp_ctl = 1'b0; tick(1);
    chk("R12 off", out_clamped, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule